// File: doc/BRIEF.md
# Processor Interrupt Delivery Controller

This block sits beside a single processor core and turns asynchronous-looking request events into exceptions that the core takes only at instruction boundaries. It holds three kinds of request: a reset request, a non-maskable request, and a leveled interrupt whose value is a 6-bit pattern. It also owns the hardware-pending field of the core's cause register. Requests are remembered in pending state until the core retires an instruction. At that point the block picks the single most urgent request and acts on it.

Reset and non-maskable requests always win, and they both raise the same combined exception type. A leveled request first writes its pattern into the cause field. It raises an interrupt exception only when the core's status register has interrupts globally enabled and the level shares a set bit with the 6-bit mask. If it is not enabled or is masked, it stays pending and is tried again at every later retire. A level of zero withdraws the interrupt. When a withdrawal is serviced, the cause field is cleared and no exception is raised.

All pins are plain control and status signals. Nothing flows in bursts, so no valid/ready handshake is used and there is no back-pressure: every request and retire strobe is taken in the cycle it is presented.

Top module: `irq_deliver_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all pending requests and `cause_ip` are cleared. After that edge `exc_valid` is 0, `exc_type` is 2'b00 and `cause_ip` is 0, and a later retire with no new request raises nothing.
- R2: A `req_reset` pulse makes the next retire raise a one-cycle `exc_valid` with `exc_type` 2'b01. The request is then consumed, so a further retire raises nothing.
- R3: A `req_nmi` pulse raises `exc_type` 2'b01 in the same way. When a reset request and a non-maskable request are both pending, each retire services only one of them: two retires give two exceptions and a third gives none.
- R4: A reset or non-maskable request is serviced ahead of a pending enabled level, and it leaves `cause_ip` unchanged. The level remains pending and is delivered at the following retire.
- R5: A level event with a nonzero `lvl_val` makes the next retire write `lvl_val` into `cause_ip`. If `st_ie` is 1 and `lvl_val & st_mask` is nonzero, that retire also raises `exc_type` 2'b10 (interrupt) for one cycle, and the level is consumed. `cause_ip` keeps the value afterwards.
- R6: If `st_ie` is 0 or `lvl_val & st_mask` is zero at a retire, no exception is raised and the level stays pending. The first later retire at which it is enabled and unmasked delivers it.
- R7: A level event with `lvl_val` equal to 0 is a withdrawal. The next retire clears `cause_ip` to 0 and raises no exception, and the withdrawn level is never delivered afterwards.
- R8: A new level event replaces any level still pending, whether it was a request or a withdrawal.
- R9: Nothing is delivered without a retire. `exc_valid` is high only in the cycle after a clock edge that sampled `retire` high, and `cause_ip` changes only after such an edge or after reset.
- R10: A request event in the same cycle as a retire is not seen by that retire. It is serviced at the next retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_reset | input | 1 | One-cycle reset request event |
| req_nmi | input | 1 | One-cycle non-maskable request event |
| lvl_evt | input | 1 | One-cycle strobe: `lvl_val` carries a new level |
| lvl_val | input | 6 | Level pattern; 0 means withdraw |
| st_ie | input | 1 | Status register global interrupt enable |
| st_mask | input | 6 | Status register interrupt mask field |
| retire | input | 1 | Instruction-retire strobe; evaluation point |
| exc_valid | output | 1 | One-cycle exception request |
| exc_type | output | 2 | 00 none, 01 reset/NMI, 10 interrupt |
| cause_ip | output | 6 | Hardware-pending field of the cause register |

## Verification
The level path is tried in several ways. A mask that overlaps the level is used, and so are a disjoint mask and a cleared enable. Together these separate the enable test from the mask test and show that a blocked level is retried rather than dropped. Stacked reset, NMI and level requests show that only one request is serviced per retire and that the level waits without losing its cause value. Withdrawal, overwrite and same-cycle event/retire patterns show the difference between a clear and an idle state, and when a new request first becomes visible.

// File: rtl/irq_deliver_pkg.sv
package irq_deliver_pkg;
  typedef enum logic [1:0] {
    EXC_NONE   = 2'b00,
    EXC_NMIRST = 2'b01,
    EXC_INT    = 2'b10
  } exc_code_t;

  typedef enum logic [1:0] {
    LV_IDLE  = 2'b00,
    LV_REQ   = 2'b01,
    LV_WDRAW = 2'b10
  } lv_state_t;
endpackage

// File: rtl/evt_flag.sv
module evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // A new event wins over a same-cycle service.
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/level_track.sv
module level_track
  import irq_deliver_pkg::*;
#(
  parameter int IP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            evt_i,
  input  logic [IP_W-1:0] val_i,
  input  logic            done_i,
  output lv_state_t       state_o,
  output logic [IP_W-1:0] val_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= LV_IDLE;
      val_o   <= '0;
    end else if (evt_i) begin
      state_o <= (val_i == '0) ? LV_WDRAW : LV_REQ;
      val_o   <= val_i;
    end else if (done_i) begin
      state_o <= LV_IDLE;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_deliver_pkg::*;
#(
  parameter int IP_W = 6
) (
  input  logic            eval_i,
  input  logic            rst_pend_i,
  input  logic            nmi_pend_i,
  input  lv_state_t       lv_state_i,
  input  logic [IP_W-1:0] lv_val_i,
  input  logic            ie_i,
  input  logic [IP_W-1:0] mask_i,
  output logic            clr_rst_o,
  output logic            clr_nmi_o,
  output logic            lv_done_o,
  output logic            cause_we_o,
  output logic [IP_W-1:0] cause_d_o,
  output logic            fire_o,
  output exc_code_t       code_o
);
  logic lv_open;
  assign lv_open = ie_i && ((lv_val_i & mask_i) != '0);

  always_comb begin
    clr_rst_o  = 1'b0;
    clr_nmi_o  = 1'b0;
    lv_done_o  = 1'b0;
    cause_we_o = 1'b0;
    cause_d_o  = '0;
    fire_o     = 1'b0;
    code_o     = EXC_NONE;
    if (eval_i) begin
      if (rst_pend_i) begin
        clr_rst_o = 1'b1;
        fire_o    = 1'b1;
        code_o    = EXC_NMIRST;
      end else if (nmi_pend_i) begin
        clr_nmi_o = 1'b1;
        fire_o    = 1'b1;
        code_o    = EXC_NMIRST;
      end else if (lv_state_i == LV_WDRAW) begin
        cause_we_o = 1'b1;
        lv_done_o  = 1'b1;
      end else if (lv_state_i == LV_REQ) begin
        cause_we_o = 1'b1;
        cause_d_o  = lv_val_i;
        if (lv_open) begin
          lv_done_o = 1'b1;
          fire_o    = 1'b1;
          code_o    = EXC_INT;
        end
      end
    end
  end
endmodule

// File: rtl/irq_deliver_ctrl.sv
module irq_deliver_ctrl
  import irq_deliver_pkg::*;
#(
  parameter int IP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_reset,
  input  logic            req_nmi,
  input  logic            lvl_evt,
  input  logic [IP_W-1:0] lvl_val,
  input  logic            st_ie,
  input  logic [IP_W-1:0] st_mask,
  input  logic            retire,
  output logic            exc_valid,
  output logic [1:0]      exc_type,
  output logic [IP_W-1:0] cause_ip
);
  localparam int NSRC = 2; // index 0 reset, 1 NMI (priority order)

  logic [NSRC-1:0] src_set, src_clr, src_pend;
  lv_state_t       lv_state;
  logic [IP_W-1:0] lv_val;
  logic            lv_done, cause_we, fire;
  logic [IP_W-1:0] cause_d;
  exc_code_t       code;

  assign src_set = {req_nmi, req_reset};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    evt_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (src_set[g]),
      .clr_i  (src_clr[g]),
      .pend_o (src_pend[g])
    );
  end

  level_track #(.IP_W(IP_W)) u_lvl (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (lvl_evt),
    .val_i   (lvl_val),
    .done_i  (lv_done),
    .state_o (lv_state),
    .val_o   (lv_val)
  );

  irq_arbiter #(.IP_W(IP_W)) u_arb (
    .eval_i     (retire),
    .rst_pend_i (src_pend[0]),
    .nmi_pend_i (src_pend[1]),
    .lv_state_i (lv_state),
    .lv_val_i   (lv_val),
    .ie_i       (st_ie),
    .mask_i     (st_mask),
    .clr_rst_o  (src_clr[0]),
    .clr_nmi_o  (src_clr[1]),
    .lv_done_o  (lv_done),
    .cause_we_o (cause_we),
    .cause_d_o  (cause_d),
    .fire_o     (fire),
    .code_o     (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_type  <= EXC_NONE;
      cause_ip  <= '0;
    end else begin
      exc_valid <= fire;
      exc_type  <= code;
      if (cause_we) cause_ip <= cause_d;
    end
  end
endmodule

// File: rtl/irq_deliver_chk.sv
module irq_deliver_chk #(
  parameter int IP_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            retire,
  input logic            st_ie,
  input logic [IP_W-1:0] st_mask,
  input logic [1:0]      src_pend,
  input logic            exc_valid,
  input logic [1:0]      exc_type,
  input logic [IP_W-1:0] cause_ip
);
  // R9: an exception follows a retire
  a_r9_exc_after_retire: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> $past(retire));

  // R9: cause field moves only after a retire or reset
  a_r9_cause_after_retire: assert property (@(posedge clk) disable iff (rst)
    !$stable(cause_ip) |-> ($past(retire) || $past(rst)));

  // R2: valid carries a real code, idle carries none
  a_r2_type_matches_valid: assert property (@(posedge clk) disable iff (rst)
    exc_valid == (exc_type != 2'b00));

  // R5: interrupt only when enabled and unmasked
  a_r5_int_enabled: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_type == 2'b10) |-> ($past(st_ie) && (($past(st_mask) & cause_ip) != '0)));

  // R3: a pending reset or NMI request is serviced at the retire
  a_r3_high_prio_first: assert property (@(posedge clk) disable iff (rst)
    (retire && (src_pend != 2'b00)) |=> (exc_valid && exc_type == 2'b01));
endmodule

bind irq_deliver_ctrl irq_deliver_chk #(.IP_W(IP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .retire    (retire),
  .st_ie     (st_ie),
  .st_mask   (st_mask),
  .src_pend  (src_pend),
  .exc_valid (exc_valid),
  .exc_type  (exc_type),
  .cause_ip  (cause_ip)
);

// File: tb/irq_deliver_ctrl_test.sv
module irq_deliver_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_reset = 1'b0, req_nmi = 1'b0, lvl_evt = 1'b0, retire = 1'b0;
  logic [5:0] lvl_val = '0, st_mask = '0;
  logic       st_ie = 1'b0;
  logic       exc_valid;
  logic [1:0] exc_type;
  logic [5:0] cause_ip;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_deliver_ctrl uut (
    .clk(clk), .rst(rst), .req_reset(req_reset), .req_nmi(req_nmi),
    .lvl_evt(lvl_evt), .lvl_val(lvl_val), .st_ie(st_ie), .st_mask(st_mask),
    .retire(retire), .exc_valid(exc_valid), .exc_type(exc_type), .cause_ip(cause_ip)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Retire once; check outputs in the cycle after the edge and the pulse width.
  task automatic do_retire(string req, int ev, int et, int ec);
    @(negedge clk) retire = 1'b1;
    @(posedge clk) #1;
    chk({req, " valid"}, exc_valid, ev);
    chk({req, " type"}, exc_type, et);
    chk({req, " cause"}, cause_ip, ec);
    @(negedge clk) retire = 1'b0;
    @(posedge clk) #1;
    chk({req, " pulse"}, exc_valid, 0);
  endtask

  task automatic ev_reset();
    @(negedge clk) req_reset = 1'b1;
    @(negedge clk) req_reset = 1'b0;
  endtask
  task automatic ev_nmi();
    @(negedge clk) req_nmi = 1'b1;
    @(negedge clk) req_nmi = 1'b0;
  endtask
  task automatic ev_lvl(logic [5:0] v);
    @(negedge clk) begin lvl_evt = 1'b1; lvl_val = v; end
    @(negedge clk) lvl_evt = 1'b0;
  endtask
  task automatic set_st(logic ie, logic [5:0] m);
    @(negedge clk) begin st_ie = ie; st_mask = m; end
  endtask

  task automatic t_reset_state();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 valid", exc_valid, 0);
    chk("R1 type", exc_type, 0);
    chk("R1 cause", cause_ip, 0);
    @(negedge clk) rst = 1'b0;
    do_retire("R1 idle retire", 0, 0, 0);
  endtask

  task automatic t_reset_req();
    ev_reset();
    repeat (3) @(posedge clk);
    #1 chk("R9 no retire", exc_valid, 0);
    do_retire("R2 reset req", 1, 1, 0);
    do_retire("R2 consumed", 0, 0, 0);
  endtask

  task automatic t_both_high();
    ev_reset();
    ev_nmi();
    do_retire("R3 first", 1, 1, 0);
    do_retire("R3 second", 1, 1, 0);
    do_retire("R3 third", 0, 0, 0);
  endtask

  task automatic t_level_ok();
    set_st(1'b1, 6'b000100);
    ev_lvl(6'b000110);
    do_retire("R5 deliver", 1, 2, 6);
    do_retire("R5 consumed", 0, 0, 6);
  endtask

  task automatic t_masked();
    set_st(1'b1, 6'b110000);
    ev_lvl(6'b000011);
    do_retire("R6 masked", 0, 0, 3);
    do_retire("R6 retry", 0, 0, 3);
    set_st(1'b0, 6'b000001);
    do_retire("R6 ie off", 0, 0, 3);
    set_st(1'b1, 6'b000001);
    do_retire("R6 opened", 1, 2, 3);
  endtask

  task automatic t_prio_level();
    set_st(1'b1, 6'b111111);
    ev_lvl(6'b100000);
    ev_nmi();
    do_retire("R4 nmi first", 1, 1, 3);
    do_retire("R4 level next", 1, 2, 32);
  endtask

  task automatic t_withdraw();
    set_st(1'b0, 6'b111111);
    ev_lvl(6'b001000);
    do_retire("R7 pending", 0, 0, 8);
    ev_lvl(6'b000000);
    set_st(1'b1, 6'b111111);
    do_retire("R7 withdraw", 0, 0, 0);
    do_retire("R7 gone", 0, 0, 0);
  endtask

  task automatic t_overwrite();
    set_st(1'b1, 6'b000010);
    ev_lvl(6'b000001);
    ev_lvl(6'b000010);
    do_retire("R8 overwrite", 1, 2, 2);
    ev_lvl(6'b000000);
    ev_lvl(6'b010000);
    set_st(1'b1, 6'b010000);
    do_retire("R8 over withdraw", 1, 2, 16);
  endtask

  task automatic t_same_cycle();
    @(negedge clk) begin req_nmi = 1'b1; retire = 1'b1; end
    @(posedge clk) #1 chk("R10 unseen", exc_valid, 0);
    @(negedge clk) begin req_nmi = 1'b0; retire = 1'b0; end
    do_retire("R10 next retire", 1, 1, 16);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_reset_req();
        t_both_high();
        t_level_ok();
        t_masked();
        t_prio_level();
        t_withdraw();
        t_overwrite();
        t_same_cycle();
        ev_lvl(6'b000101);
        t_reset_state();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule